// File: doc/BRIEF.md
# Bubble-Through FIFO with Ready Handshake

This block is a first-in first-out buffer built as a chain of register stages, each stage with its own occupancy bit. A word written at the input stage falls toward the output stage at one stage per clock while the stage ahead is empty. A freed location at the output travels back toward the input at the same rate. The time from entry to exit therefore depends on how full the chain is, and the status flags describe the two end stages, not a pointer difference.

The producer offers a word by pulsing `shift_in` for one cycle while `in_rdy` is high. The consumer takes the word on `dout` by pulsing `shift_out` for one cycle while `out_rdy` is high. Two units chain into a buffer of twice the depth: the first unit's `out_rdy` drives the second unit's `shift_in`, the second unit's `in_rdy` drives the first unit's `shift_out`, and the first unit's `dout` feeds the second unit's `din`. An asynchronous master reset empties every stage.

Top module: `bubble_fifo`

## Requirements
- R1: While or right after `mrst` is high, `in_rdy` is 1, `out_rdy` is 0 and `dout` is all zeros.
- R2: Words leave on `dout` in the order they were accepted, including when shifts in and out interleave.
- R3: The buffer holds exactly DEPTH words; once DEPTH words are stored and the chain has settled, `in_rdy` is 0 and `out_rdy` is 1.
- R4: A `shift_in` pulse while `in_rdy` is 0 stores nothing and does not alter the stored words or the occupancy.
- R5: A word accepted at clock edge k into an empty buffer makes `out_rdy` 1 after edge k+DEPTH-1 and not before.
- R6: After one word is shifted out of a full buffer at edge k, `in_rdy` stays 0 until edge k+DEPTH-1 and is 1 after it; the next word appears on `dout` after edge k+1.
- R7: After the last word is shifted out, `out_rdy` is 0, further `shift_out` pulses have no effect, and `dout` keeps showing that last word.
- R8: `out_rdy` falls only in the cycle after an accepted `shift_out`, and `in_rdy` falls only in the cycle after an accepted `shift_in`.
- R9: Two cascaded units store 2*DEPTH words in order; once full, the first unit's `in_rdy` stays 0 and further input is ignored.
- R10: The stored word count changes by at most one per clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| mrst | input | 1 | Asynchronous master reset, active high |
| shift_in | input | 1 | One-cycle strobe to write `din` |
| din | input | WIDTH | Word to write |
| shift_out | input | 1 | One-cycle strobe to remove the word on `dout` |
| dout | output | WIDTH | Word held in the output stage |
| in_rdy | output | 1 | Input stage is empty |
| out_rdy | output | 1 | Output stage holds a valid word |

## Verification
The bench builds every instance with the default DEPTH of 64 and WIDTH of 4, so the full-depth fall-through delay of 63 edges and the bubble return delay are measured at their real length. With a 64-stage chain the standalone fill, the bubble timing and a 128-word cascade all complete in a few thousand cycles. A 4-bit word keeps the data patterns cheap but still lets order errors show, because successive words differ.

// File: rtl/bubble_fifo.sv
module bubble_fifo #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             mrst,
  input  logic             shift_in,
  input  logic [WIDTH-1:0] din,
  input  logic             shift_out,
  output logic [WIDTH-1:0] dout,
  output logic             in_rdy,
  output logic             out_rdy
);
  localparam int LAST = DEPTH - 1;

  logic [DEPTH-1:0] vld;
  logic [DEPTH-1:0] vld_nx;
  logic [LAST-1:0]  adv;
  logic [WIDTH-1:0] word_q [DEPTH];
  logic             take;
  logic             give;

  assign in_rdy  = ~vld[0];
  assign out_rdy = vld[LAST];
  assign dout    = word_q[LAST];
  assign take    = shift_in & in_rdy;
  assign give    = shift_out & out_rdy;

  // a word moves only into a stage that was empty at this edge
  assign adv = vld[LAST-1:0] & ~vld[LAST:1];

  always_comb begin
    vld_nx[0] = take | (vld[0] & ~adv[0]);
    for (int i = 1; i < LAST; i++)
      vld_nx[i] = adv[i-1] | (vld[i] & ~adv[i]);
    vld_nx[LAST] = adv[LAST-1] | (vld[LAST] & ~give);
  end

  always_ff @(posedge clk or posedge mrst) begin
    if (mrst) begin
      vld <= '0;
      for (int i = 0; i < DEPTH; i++) word_q[i] <= '0;
    end else begin
      vld <= vld_nx;
      if (take) word_q[0] <= din;
      for (int i = 1; i < DEPTH; i++)
        if (adv[i-1]) word_q[i] <= word_q[i-1];
    end
  end
endmodule

// File: rtl/bubble_fifo_chk.sv
module bubble_fifo_chk #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             mrst,
  input logic             shift_in,
  input logic             shift_out,
  input logic [WIDTH-1:0] dout,
  input logic             in_rdy,
  input logic             out_rdy,
  input logic [DEPTH-1:0] vld
);
  assert_reset_flags_R1: assert property (@(posedge clk)
    $past(mrst) |-> (in_rdy && !out_rdy));

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (mrst)
    (shift_in && !in_rdy) |=> ($countones(vld) <= $past($countones(vld))));

  assert_dout_hold_R7: assert property (@(posedge clk) disable iff (mrst)
    (shift_out && !out_rdy && !vld[DEPTH-2]) |=> $stable(dout));

  assert_out_rdy_fall_R8: assert property (@(posedge clk) disable iff (mrst)
    (out_rdy && !shift_out) |=> out_rdy);

  assert_in_rdy_fall_R8: assert property (@(posedge clk) disable iff (mrst)
    (in_rdy && !shift_in) |=> in_rdy);

  assert_step_up_R10: assert property (@(posedge clk) disable iff (mrst)
    1'b1 |=> ($countones(vld) <= $past($countones(vld)) + 1));

  assert_step_down_R10: assert property (@(posedge clk) disable iff (mrst)
    1'b1 |=> ($countones(vld) + 1 >= $past($countones(vld))));
endmodule

bind bubble_fifo bubble_fifo_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_chk (
  .clk(clk), .mrst(mrst), .shift_in(shift_in), .shift_out(shift_out),
  .dout(dout), .in_rdy(in_rdy), .out_rdy(out_rdy), .vld(vld)
);

// File: tb/test_bubble_fifo.sv
module test_bubble_fifo;
  localparam int DEPTH = 64;
  localparam int WIDTH = 4;

  logic clk = 1'b0;
  logic mrst = 1'b1;
  always #5 clk = ~clk;

  logic si = 1'b0, so = 1'b0;
  logic [WIDTH-1:0] din = '0, dout;
  logic ir, orr;

  bubble_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) i_bubble_fifo (
    .clk(clk), .mrst(mrst), .shift_in(si), .din(din), .shift_out(so),
    .dout(dout), .in_rdy(ir), .out_rdy(orr));

  logic csi = 1'b0, cso = 1'b0;
  logic [WIDTH-1:0] cdin = '0, mid_d, cdout;
  logic cir, mid_r, back_r, corr;

  bubble_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) i_bubble_fifo_head (
    .clk(clk), .mrst(mrst), .shift_in(csi), .din(cdin), .shift_out(back_r),
    .dout(mid_d), .in_rdy(cir), .out_rdy(mid_r));
  bubble_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) i_bubble_fifo_tail (
    .clk(clk), .mrst(mrst), .shift_in(mid_r), .din(mid_d), .shift_out(cso),
    .dout(cdout), .in_rdy(back_r), .out_rdy(corr));

  int n_chk = 0, n_fail = 0;
  logic [WIDTH-1:0] q[$];
  logic [WIDTH-1:0] cq[$];

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic push(input logic [WIDTH-1:0] w);
    while (!ir) @(negedge clk);
    si = 1'b1; din = w; q.push_back(w);
    @(negedge clk);
    si = 1'b0;
  endtask

  task automatic pop(input string tag);
    logic [WIDTH-1:0] e;
    while (!orr) @(negedge clk);
    e = q.pop_front();
    chk(tag, dout, e);
    so = 1'b1;
    @(negedge clk);
    so = 1'b0;
  endtask

  task automatic do_reset();
    mrst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 in_rdy in reset", ir, 1);
    chk("R1 out_rdy in reset", orr, 0);
    chk("R1 dout in reset", dout, 0);
    mrst = 1'b0;
    @(negedge clk);
    chk("R1 in_rdy after reset", ir, 1);
    chk("R1 out_rdy after reset", orr, 0);
    q.delete(); cq.delete();
  endtask

  task automatic t_latency();
    si = 1'b1; din = 4'hA;
    @(negedge clk);
    si = 1'b0;
    repeat (DEPTH - 2) @(negedge clk);
    chk("R5 out_rdy before edge k+DEPTH-1", orr, 0);
    @(negedge clk);
    chk("R5 out_rdy after edge k+DEPTH-1", orr, 1);
    chk("R5 dout word", dout, 4'hA);
    so = 1'b1;
    @(negedge clk);
    so = 1'b0;
    chk("R7 out_rdy after last word", orr, 0);
    chk("R7 dout keeps last word", dout, 4'hA);
    so = 1'b1;
    repeat (3) @(negedge clk);
    so = 1'b0;
    @(negedge clk);
    chk("R7 extra shift_out out_rdy", orr, 0);
    chk("R7 extra shift_out dout", dout, 4'hA);
    chk("R7 extra shift_out in_rdy", ir, 1);
  endtask

  task automatic t_fill_bubble();
    for (int i = 0; i < DEPTH; i++) push(WIDTH'(i ^ 5));
    repeat (2 * DEPTH) @(negedge clk);
    chk("R3 in_rdy when full", ir, 0);
    chk("R3 out_rdy when full", orr, 1);
    si = 1'b1; din = 4'hF;
    repeat (4) @(negedge clk);
    si = 1'b0;
    chk("R4 in_rdy after ignored shift_in", ir, 0);
    chk("R4 dout after ignored shift_in", dout, 5);
    chk("R6 dout before shift_out", dout, q[0]);
    void'(q.pop_front());
    so = 1'b1;
    @(negedge clk);
    so = 1'b0;
    chk("R6 out_rdy after edge k", orr, 0);
    @(negedge clk);
    chk("R6 out_rdy after edge k+1", orr, 1);
    chk("R6 next word after edge k+1", dout, q[0]);
    repeat (DEPTH - 3) @(negedge clk);
    chk("R6 in_rdy before edge k+DEPTH-1", ir, 0);
    @(negedge clk);
    chk("R6 in_rdy after edge k+DEPTH-1", ir, 1);
    push(4'h9);
    for (int i = 0; i < DEPTH; i++) pop("R2 drain order");
    repeat (2 * DEPTH) @(negedge clk);
    chk("R4 no extra word stored", orr, 0);
    chk("R3 in_rdy after drain", ir, 1);
  endtask

  task automatic t_interleave();
    fork
      begin
        logic [WIDTH-1:0] lf = 4'h1;
        for (int i = 0; i < 90; i++) begin
          lf = {lf[2:0], lf[3] ^ lf[2]};
          push(lf);
          if (i % 4 == 1) @(negedge clk);
        end
      end
      begin
        for (int i = 0; i < 90; i++) begin
          pop("R2 interleaved order");
          repeat (i % 3) @(negedge clk);
        end
      end
    join
    repeat (2 * DEPTH) @(negedge clk);
    chk("R2 empty after interleave", orr, 0);
  endtask

  task automatic t_cascade();
    for (int i = 0; i < 2 * DEPTH; i++) begin
      while (!cir) @(negedge clk);
      csi = 1'b1; cdin = WIDTH'(i * 7 + 3); cq.push_back(cdin);
      @(negedge clk);
      csi = 1'b0;
    end
    repeat (4 * DEPTH) @(negedge clk);
    chk("R9 head in_rdy when cascade full", cir, 0);
    chk("R9 tail out_rdy when cascade full", corr, 1);
    csi = 1'b1; cdin = 4'hE;
    repeat (3) @(negedge clk);
    csi = 1'b0;
    repeat (4) @(negedge clk);
    chk("R9 head in_rdy stays low", cir, 0);
    for (int i = 0; i < 2 * DEPTH; i++) begin
      logic [WIDTH-1:0] e;
      while (!corr) @(negedge clk);
      e = cq.pop_front();
      chk("R9 cascade order", cdout, e);
      cso = 1'b1;
      @(negedge clk);
      cso = 1'b0;
    end
    repeat (4 * DEPTH) @(negedge clk);
    chk("R9 cascade empty after drain", corr, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog (all R): actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    do_reset();
    t_latency();
    do_reset();
    t_fill_bubble();
    do_reset();
    t_interleave();
    do_reset();
    t_cascade();
    summary();
    $finish;
  end
endmodule